// File: doc/BRIEF.md
# Map-Reduce Stencil Unit

This block is a pipelined datapath that takes a whole stencil window of unsigned pixels together with a matching array of stationary operands. It applies one elementwise operation to each pixel and its operand, then folds the per-element results into one answer per window. The stationary operands are values that stay fixed while the caller slides the window over an image. They can be filter taps, the pixels of a current block being matched, or a centre pixel copied into every lane for a local maximum or minimum test. The caller picks the operation pair per window. The same hardware therefore computes sums of absolute differences for block matching, signed dot products for FIR filtering, per-pixel differences between two images, and extremum flags over a three-plane neighbourhood.

Each window arrives as a set of lanes. Lane `i` occupies bits `[8i+7:8i]` of the pixel and operand buses and bit `i` of the lane mask. Lanes outside the stencil are switched off through the mask. With the default of 27 lanes, the bus holds a 9×3 compare neighbourhood, and a 4×4 block uses lanes 0 to 15.

Input and output are valid/ready streams. A window transfers on a clock edge where `in_valid` and `in_ready` are both high. A result transfers on an edge where `out_valid` and `out_ready` are both high. When `out_ready` is low while a result is pending, the whole pipeline freezes, the result stays on the outputs unchanged, and `in_ready` drops. `in_ready` never depends on `in_valid`.

Top module: `stencil_mapred`

## Requirements
- R1: Element op code 0 with fold code 0 gives `out_sum` equal to the sum over enabled lanes of |pixel − operand|, with both treated as unsigned. A 4×4 block uses lanes 0 to 15.
- R2: Element op code 1 with fold code 0 gives `out_sum` equal to the sum over enabled lanes of pixel (unsigned) × operand (8-bit two's complement). The sum is exact over all 27 lanes.
- R3: Element op code 3 with fold code 1 raises `out_flag` only when every enabled lane is strictly greater than its operand (`in_cmp_min`=0) or strictly less than it (`in_cmp_min`=1). An equal lane clears the flag.
- R4: Element op code 2 with fold code 2 puts pixel − operand, as a 16-bit signed value, in `out_elem` lane `i` (bits `[16i+15:16i]`). Masked lanes read zero.
- R5: A masked lane (`in_mask[i]`=0) adds nothing to a sum and counts as true for the AND fold. With no lane enabled, the AND fold gives 1 and the sum fold gives 0.
- R6: Only the chosen fold drives its output. `out_sum` is zero unless the fold code is 0, `out_flag` is zero unless the fold code is 1, and `out_elem` is zero unless the fold code is 2 or 3. Code 3 acts exactly like code 2.
- R7: While `out_ready` stays high, a window accepted in cycle c appears with `out_valid` in cycle c+2. A new window is accepted every cycle.
- R8: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_sum`, `out_flag` and `out_elem` hold steady. Results leave in the order their windows were accepted, and none is lost or repeated.
- R9: While `rst_n` is low and after it is released, `out_valid` is 0 and `in_ready` is 1 until a window is accepted.
- R10: The AND fold is true for a lane whose element result is nonzero. Element op code 3 with fold code 0 gives the count of enabled lanes that pass the compare test.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Window present on the input buses |
| in_ready | output | 1 | Unit can take a window this cycle |
| in_pix | input | N_ELEM*PIX_W | Window pixels, unsigned, lane i at [8i+7:8i] |
| in_ref | input | N_ELEM*PIX_W | Stationary operands, lane i at [8i+7:8i] |
| in_mask | input | N_ELEM | Lane enable, 1 = lane is inside the stencil |
| in_map | input | 2 | Element op: 0 abs diff, 1 multiply, 2 subtract, 3 compare |
| in_red | input | 2 | Fold: 0 sum, 1 AND, 2 or 3 none |
| in_cmp_min | input | 1 | Compare test: 0 strictly greater, 1 strictly less |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_sum | output | SUM_W | Signed sum fold result |
| out_flag | output | 1 | AND fold result |
| out_elem | output | N_ELEM*2*PIX_W | Per-lane signed element results for fold none |

## Verification
A fault in a lane's element logic shows up in the first result that uses that lane and that op. It appears two cycles after the window enters, as a wrong `out_sum`, a wrong `out_flag`, or one wrong 16-bit field of `out_elem`. A fault in the fold tree affects every window that uses that fold. A fault in the stage registers or the stall enable shows up instead as a result that changes while it is held, a gap in output timing, or a result that is dropped, repeated or reordered. A per-cycle reference queue sees such a fault on the first output transfer after it. A stale fold selection is seen as soon as a window with a different fold code follows one with a nonzero result.

// File: rtl/stmr_pkg.sv
`timescale 1ns/1ps
package stmr_pkg;

  typedef enum logic [1:0] {
    MAP_ABSDIFF = 2'd0,
    MAP_MUL     = 2'd1,
    MAP_SUB     = 2'd2,
    MAP_CMP     = 2'd3
  } map_op_e;

  typedef enum logic [1:0] {
    RED_SUM      = 2'd0,
    RED_AND      = 2'd1,
    RED_NONE     = 2'd2,
    RED_NONE_ALT = 2'd3
  } red_op_e;

endpackage

// File: rtl/stmr_map_lane.sv
`timescale 1ns/1ps
// One lane of the elementwise stage: combines a pixel with its stationary operand.
module stmr_map_lane
  import stmr_pkg::*;
#(
  parameter int PIX_W = 8,
  localparam int EL_W = 2 * PIX_W
) (
  input  logic                   en,
  input  logic [PIX_W-1:0]       pix,
  input  logic [PIX_W-1:0]       refv,
  input  logic [1:0]             op,
  input  logic                   cmp_min,
  output logic signed [EL_W-1:0] val,
  output logic                   tru
);

  logic signed [EL_W-1:0] pix_z;
  logic signed [EL_W-1:0] ref_z;
  logic signed [EL_W-1:0] ref_s;
  logic signed [EL_W-1:0] raw;
  logic                   hit;

  always_comb begin
    pix_z = {{(EL_W-PIX_W){1'b0}}, pix};
    ref_z = {{(EL_W-PIX_W){1'b0}}, refv};
    ref_s = {{(EL_W-PIX_W){refv[PIX_W-1]}}, refv};
    hit   = cmp_min ? (pix < refv) : (pix > refv);
    case (map_op_e'(op))
      MAP_ABSDIFF: raw = (pix >= refv) ? (pix_z - ref_z) : (ref_z - pix_z);
      MAP_MUL:     raw = pix_z * ref_s;
      MAP_SUB:     raw = pix_z - ref_z;
      default:     raw = {{(EL_W-1){1'b0}}, hit};
    endcase
    val = en ? raw : '0;
    tru = en ? (raw != '0) : 1'b1;
  end

endmodule

// File: rtl/stmr_reduce.sv
`timescale 1ns/1ps
// Balanced fold trees: signed sum and logical AND over all lanes.
module stmr_reduce #(
  parameter int N_ELEM = 27,
  parameter int EL_W   = 16,
  parameter int SUM_W  = 21,
  localparam int LEVELS = (N_ELEM > 1) ? $clog2(N_ELEM) : 1,
  localparam int P      = 1 << LEVELS
) (
  input  logic signed [EL_W-1:0]  vals [N_ELEM],
  input  logic                    tru  [N_ELEM],
  output logic signed [SUM_W-1:0] sum,
  output logic                    all_true
);

  logic signed [SUM_W-1:0] s_node [1:2*P-1];
  logic                    a_node [1:2*P-1];

  for (genvar i = 0; i < P; i++) begin : g_leaf
    if (i < N_ELEM) begin : g_used
      assign s_node[P+i] = {{(SUM_W-EL_W){vals[i][EL_W-1]}}, vals[i]};
      assign a_node[P+i] = tru[i];
    end else begin : g_pad
      assign s_node[P+i] = '0;
      assign a_node[P+i] = 1'b1;
    end
  end

  for (genvar k = 1; k < P; k++) begin : g_node
    assign s_node[k] = s_node[2*k] + s_node[2*k+1];
    assign a_node[k] = a_node[2*k] & a_node[2*k+1];
  end

  assign sum      = s_node[1];
  assign all_true = a_node[1];

endmodule

// File: rtl/stencil_mapred.sv
`timescale 1ns/1ps
// Two-stage map-reduce stencil datapath with a valid/ready stream at each side.
module stencil_mapred
  import stmr_pkg::*;
#(
  parameter int N_ELEM = 27,
  parameter int PIX_W  = 8,
  localparam int EL_W  = 2 * PIX_W,
  localparam int SUM_W = EL_W + $clog2(N_ELEM)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [N_ELEM*PIX_W-1:0] in_pix,
  input  logic [N_ELEM*PIX_W-1:0] in_ref,
  input  logic [N_ELEM-1:0]       in_mask,
  input  logic [1:0]              in_map,
  input  logic [1:0]              in_red,
  input  logic                    in_cmp_min,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [SUM_W-1:0]        out_sum,
  output logic                    out_flag,
  output logic [N_ELEM*EL_W-1:0]  out_elem
);

  logic                    adv;
  logic signed [EL_W-1:0]  lane_val [N_ELEM];
  logic                    lane_tru [N_ELEM];
  logic signed [EL_W-1:0]  s1_val   [N_ELEM];
  logic                    s1_tru   [N_ELEM];
  red_op_e                 s1_red;
  logic                    s1_v;
  logic signed [SUM_W-1:0] fold_sum;
  logic                    fold_all;
  logic [N_ELEM*EL_W-1:0]  elem_nxt;
  logic                    keep_elem;

  // The pipeline moves only when the output slot is free or being drained.
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  for (genvar g = 0; g < N_ELEM; g++) begin : g_lane
    stmr_map_lane #(.PIX_W(PIX_W)) u_lane (
      .en      (in_mask[g]),
      .pix     (in_pix[g*PIX_W +: PIX_W]),
      .refv    (in_ref[g*PIX_W +: PIX_W]),
      .op      (in_map),
      .cmp_min (in_cmp_min),
      .val     (lane_val[g]),
      .tru     (lane_tru[g])
    );
  end

  // Stage 1: element results.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v   <= 1'b0;
      s1_red <= RED_SUM;
      for (int i = 0; i < N_ELEM; i++) begin
        s1_val[i] <= '0;
        s1_tru[i] <= 1'b1;
      end
    end else if (adv) begin
      s1_v   <= in_valid;
      s1_red <= red_op_e'(in_red);
      for (int i = 0; i < N_ELEM; i++) begin
        s1_val[i] <= lane_val[i];
        s1_tru[i] <= lane_tru[i];
      end
    end
  end

  stmr_reduce #(.N_ELEM(N_ELEM), .EL_W(EL_W), .SUM_W(SUM_W)) u_fold (
    .vals     (s1_val),
    .tru      (s1_tru),
    .sum      (fold_sum),
    .all_true (fold_all)
  );

  assign keep_elem = (s1_red == RED_NONE) || (s1_red == RED_NONE_ALT);

  always_comb begin
    for (int i = 0; i < N_ELEM; i++) begin
      elem_nxt[i*EL_W +: EL_W] = keep_elem ? s1_val[i] : '0;
    end
  end

  // Stage 2: folded result, only the selected output is nonzero.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sum   <= '0;
      out_flag  <= 1'b0;
      out_elem  <= '0;
    end else if (adv) begin
      out_valid <= s1_v;
      out_sum   <= (s1_red == RED_SUM) ? fold_sum : '0;
      out_flag  <= (s1_red == RED_AND) ? fold_all : 1'b0;
      out_elem  <= elem_nxt;
    end
  end

endmodule

// File: rtl/stmr_checker.sv
`timescale 1ns/1ps
module stmr_checker #(
  parameter int N_ELEM = 27,
  parameter int PIX_W  = 8,
  localparam int EL_W  = 2 * PIX_W,
  localparam int SUM_W = EL_W + $clog2(N_ELEM)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic                   in_ready,
  input logic [1:0]             in_map,
  input logic [1:0]             in_red,
  input logic                   out_valid,
  input logic                   out_ready,
  input logic [SUM_W-1:0]       out_sum,
  input logic                   out_flag,
  input logic [N_ELEM*EL_W-1:0] out_elem
);

  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> !out_valid); // R9

  AST_LATENCY_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) ##1 out_ready |=> out_valid); // R7

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sum) && $stable(out_flag) && $stable(out_elem))); // R8

  AST_EMPTY_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready); // R8

  AST_SAD_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_map == 2'd0 && in_red == 2'd0) ##1 out_ready |=> !out_sum[SUM_W-1]); // R1

  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_flag) |-> (out_sum == '0 && out_elem == '0)); // R6

  AST_NONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_red[1]) ##1 out_ready |=> (out_sum == '0 && !out_flag)); // R6

endmodule

bind stencil_mapred stmr_checker #(.N_ELEM(N_ELEM), .PIX_W(PIX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_map    (in_map),
  .in_red    (in_red),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_sum   (out_sum),
  .out_flag  (out_flag),
  .out_elem  (out_elem)
);

// File: tb/sim_stencil_mapred.sv
`timescale 1ns/1ps
module sim_stencil_mapred;

  localparam int N  = 27;
  localparam int PW = 8;
  localparam int EW = 2 * PW;
  localparam int SW = EW + $clog2(N);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [N*PW-1:0] in_pix = '0;
  logic [N*PW-1:0] in_ref = '0;
  logic [N-1:0]  in_mask = '0;
  logic [1:0]    in_map = 2'd0;
  logic [1:0]    in_red = 2'd0;
  logic          in_cmp_min = 1'b0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [SW-1:0] out_sum;
  logic          out_flag;
  logic [N*EW-1:0] out_elem;

  always #2 clk = ~clk;

  stencil_mapred #(.N_ELEM(N), .PIX_W(PW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_pix(in_pix), .in_ref(in_ref), .in_mask(in_mask), .in_map(in_map),
    .in_red(in_red), .in_cmp_min(in_cmp_min), .out_valid(out_valid),
    .out_ready(out_ready), .out_sum(out_sum), .out_flag(out_flag), .out_elem(out_elem)
  );

  typedef struct {
    int          sum;
    bit          flag;
    logic [N*EW-1:0] elem;
    int          acc;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  int   cyc = 0;
  int   wd = 0;
  bit   accepted;
  bit   stall_mode = 1'b0;
  bit   lat_chk = 1'b1;
  bit   hold_prev = 1'b0;
  logic [SW-1:0]   p_sum;
  logic            p_flag;
  logic [N*EW-1:0] p_elem;

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic chk(bit ok, string req, string act, string expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%s expected=%s", req, act, expv);
    end
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      summary();
      $finish;
    end
  end

  // Behavioural reference for one window.
  function automatic exp_t model(logic [N*PW-1:0] pix, logic [N*PW-1:0] rf,
                                 logic [N-1:0] mask, logic [1:0] mp, logic [1:0] rd, bit cmin);
    exp_t e;
    int s = 0;
    bit a = 1'b1;
    e.elem = '0;
    for (int i = 0; i < N; i++) begin
      int p = int'(pix[i*PW +: PW]);
      int r = int'(rf[i*PW +: PW]);
      int rs = (r >= 128) ? r - 256 : r;
      int v;
      case (mp)
        2'd0: v = (p > r) ? p - r : r - p;
        2'd1: v = p * rs;
        2'd2: v = p - r;
        default: v = cmin ? int'(p < r) : int'(p > r);
      endcase
      if (mask[i]) begin
        s += v;
        if (v == 0) a = 1'b0;
        e.elem[i*EW +: EW] = v[EW-1:0];
      end
    end
    e.sum  = (rd == 2'd0) ? s : 0;
    e.flag = (rd == 2'd1) ? a : 1'b0;
    if (rd < 2'd2) e.elem = '0;
    return e;
  endfunction

  task automatic tick();
    out_ready = stall_mode ? (($urandom % 3) != 0) : 1'b1;
    #1;
    chk(in_ready === (!out_valid || out_ready), "R8 in_ready rule",
        $sformatf("%b", in_ready), $sformatf("%b", !out_valid || out_ready));
    if (hold_prev) begin
      chk(out_valid === 1'b1 && out_sum === p_sum && out_flag === p_flag && out_elem === p_elem,
          "R8 hold under stall", $sformatf("v=%b sum=%h", out_valid, out_sum),
          $sformatf("v=1 sum=%h", p_sum));
    end
    hold_prev = out_valid && !out_ready;
    p_sum = out_sum; p_flag = out_flag; p_elem = out_elem;
    if (out_valid && out_ready) begin
      if (q.size() == 0) begin
        chk(1'b0, "R8 unexpected result", "out_valid=1", "none pending");
      end else begin
        exp_t e = q.pop_front();
        chk(int'($signed(out_sum)) == e.sum, {e.tag, " sum"},
            $sformatf("%0d", $signed(out_sum)), $sformatf("%0d", e.sum));
        chk(out_flag === e.flag, {e.tag, " flag"},
            $sformatf("%b", out_flag), $sformatf("%b", e.flag));
        chk(out_elem === e.elem, {e.tag, " elem"},
            $sformatf("%h", out_elem), $sformatf("%h", e.elem));
        if (lat_chk)
          chk(cyc - e.acc == 2, "R7 latency", $sformatf("%0d", cyc - e.acc), "2");
      end
    end
    if (in_valid && in_ready) begin
      exp_t e = model(in_pix, in_ref, in_mask, in_map, in_red, in_cmp_min);
      e.acc = cyc;
      e.tag = "";
      accepted = 1'b1;
      q.push_back(e);
    end
    @(negedge clk);
    cyc++;
  endtask

  task automatic send(logic [N*PW-1:0] pix, logic [N*PW-1:0] rf, logic [N-1:0] mask,
                      logic [1:0] mp, logic [1:0] rd, bit cmin, string tag);
    in_pix = pix; in_ref = rf; in_mask = mask; in_map = mp; in_red = rd;
    in_cmp_min = cmin; in_valid = 1'b1;
    accepted = 1'b0;
    while (!accepted) tick();
    q[q.size()-1].tag = tag;
  endtask

  task automatic drain();
    in_valid = 1'b0;
    while (q.size() != 0) tick();
    tick();
  endtask

  function automatic logic [N*PW-1:0] rnd_vec();
    logic [N*PW-1:0] v;
    for (int i = 0; i < N; i++) v[i*PW +: PW] = PW'($urandom);
    return v;
  endfunction

  function automatic logic [N*PW-1:0] fill(int val);
    logic [N*PW-1:0] v;
    for (int i = 0; i < N; i++) v[i*PW +: PW] = PW'(val);
    return v;
  endfunction

  localparam logic [N-1:0] M16  = N'(16'hFFFF);
  localparam logic [N-1:0] M6   = N'(6'h3F);
  localparam logic [N-1:0] MALL = {N{1'b1}};
  localparam int           CTR  = 13;

  initial begin
    logic [N*PW-1:0] v;
    logic [N-1:0] mnc;
    mnc = MALL;
    mnc[CTR] = 1'b0;

    // R9: reset state
    repeat (3) @(negedge clk);
    #1;
    chk(out_valid === 1'b0 && in_ready === 1'b1, "R9 during reset",
        $sformatf("v=%b r=%b", out_valid, in_ready), "v=0 r=1");
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(out_valid === 1'b0 && in_ready === 1'b1, "R9 after reset",
        $sformatf("v=%b r=%b", out_valid, in_ready), "v=0 r=1");
    @(negedge clk);

    // R1: SAD over a 4x4 block, back to back (R7 throughput)
    for (int k = 0; k < 8; k++) send(rnd_vec(), rnd_vec(), M16, 2'd0, 2'd0, 1'b0, "R1 SAD random");
    send(fill(255), fill(0), M16, 2'd0, 2'd0, 1'b0, "R1 SAD max 4080");
    send(fill(0), fill(255), M16, 2'd0, 2'd0, 1'b0, "R1 SAD reversed");
    // R2: FIR dot products
    for (int k = 0; k < 6; k++) send(rnd_vec(), rnd_vec(), M6, 2'd1, 2'd0, 1'b0, "R2 FIR 6 taps");
    send(fill(255), fill(128), MALL, 2'd1, 2'd0, 1'b0, "R2 most negative sum");
    send(fill(255), fill(127), MALL, 2'd1, 2'd0, 1'b0, "R2 most positive sum");
    send(rnd_vec(), rnd_vec(), MALL, 2'd1, 2'd0, 1'b0, "R2 full window");
    drain();

    // R3: extremum over 9x3, centre lane masked, operand = centre value
    v = fill(101);
    for (int i = 0; i < N; i++) v[i*PW +: PW] = PW'(101 + i * 3);
    send(v, fill(100), mnc, 2'd3, 2'd1, 1'b0, "R3 max true");
    v[4*PW +: PW] = 8'd100;
    send(v, fill(100), mnc, 2'd3, 2'd1, 1'b0, "R3 max equal lane false");
    v = fill(50);
    send(v, fill(100), mnc, 2'd3, 2'd1, 1'b1, "R3 min true");
    v[20*PW +: PW] = 8'd200;
    send(v, fill(100), mnc, 2'd3, 2'd1, 1'b1, "R3 min one high false");
    send(fill(50), fill(100), mnc, 2'd3, 2'd1, 1'b0, "R3 max all below false");
    // R5: masking
    send(rnd_vec(), rnd_vec(), '0, 2'd3, 2'd1, 1'b0, "R5 all masked AND");
    send(rnd_vec(), rnd_vec(), '0, 2'd1, 2'd0, 1'b0, "R5 all masked sum");
    v = fill(200);
    v[CTR*PW +: PW] = 8'd10;
    send(v, fill(100), mnc, 2'd3, 2'd1, 1'b0, "R5 masked failing lane ignored");
    // R4: per-pixel differences
    send(rnd_vec(), rnd_vec(), MALL, 2'd2, 2'd2, 1'b0, "R4 subtract none");
    send(fill(0), fill(255), M16, 2'd2, 2'd2, 1'b0, "R4 negative differences");
    // R6: fold selection
    send(rnd_vec(), rnd_vec(), MALL, 2'd2, 2'd3, 1'b0, "R6 code 3 as none");
    send(rnd_vec(), rnd_vec(), MALL, 2'd1, 2'd2, 1'b0, "R6 multiply none");
    send(rnd_vec(), rnd_vec(), MALL, 2'd0, 2'd1, 1'b0, "R6 absdiff AND");
    // R10: compare with sum counts passing lanes
    send(rnd_vec(), fill(128), MALL, 2'd3, 2'd0, 1'b0, "R10 compare count max");
    send(rnd_vec(), fill(128), mnc, 2'd3, 2'd0, 1'b1, "R10 compare count min");
    send(fill(7), fill(7), MALL, 2'd0, 2'd1, 1'b0, "R10 AND zero lanes false");
    drain();

    // R8: random back-pressure with mixed operations
    lat_chk = 1'b0;
    stall_mode = 1'b1;
    for (int k = 0; k < 60; k++) begin
      logic [1:0] mp = 2'($urandom);
      logic [1:0] rd = 2'($urandom);
      send(rnd_vec(), rnd_vec(), N'($urandom), mp, rd, 1'($urandom), "R8 stalled stream");
    end
    in_valid = 1'b0;
    repeat (5) tick();
    stall_mode = 1'b0;
    drain();
    lat_chk = 1'b1;

    // R7: single window latency after idle
    send(fill(9), fill(3), M16, 2'd0, 2'd0, 1'b0, "R7 single window");
    drain();

    summary();
    $finish;
  end

endmodule